// File: doc/BRIEF.md
# UART Modem Handshake Controller

This block sits beside an asynchronous serial transmitter and gives it the terminal-side modem handshake. It drives two outputs, DTR and RTS, both active low, and watches four active-low modem inputs: ring indicate, data-set ready, carrier detect and clear-to-send. Each input passes through a two-flop synchronizer. Any level change that follows is caught in a sticky per-line flag. The flags clear when software reads the status byte. A mask register picks which flags may raise the interrupt request.

Characters move from an upstream source to the transmitter core over a valid/ready stream. A transfer takes place in a cycle where both valid and ready are high. While the synchronized clear-to-send input is inactive (high) in modem mode, the block lowers both `tx_valid` and `up_ready`, so nothing is transferred. An offer that is not yet taken may therefore be withdrawn by flow control. The gate decision is frozen while `tx_busy` reports that the core is shifting a character, so a frame in flight always finishes. Software reaches the block through a plain register port. The port has a write strobe with a 2-bit address (0 mode, 1 command, 2 interrupt mask, 3 unused) and a read strobe that returns the status byte. The status byte is always visible on `rd_data`, and `rd_en` marks the cycle in which it is consumed.

Top module: `uart_modem_ctrl`

## Requirements
- R1: The block is in modem mode only while the 4-bit mode register (address 0, data bits 3:0) holds 4'h3. Every other value, including 4'hB, is not modem mode.
- R2: In modem mode, a command write (address 1) with bit 0 set and bit 1 clear makes `dtr_o` low from the next cycle. A command write with bit 1 set makes `dtr_o` high from the next cycle, whatever bit 0 is.
- R3: Outside modem mode, `dtr_o` and `rts_o` stay high, no change flag is set, and clear-to-send does not gate the stream.
- R4: In modem mode, a level change on a modem input sets its flag in status bits 3:0 three clock edges after the change. The bit order is 0 ring, 1 data-set ready, 2 carrier, 3 clear-to-send. Status bits 7:4 show the synchronized levels of the same lines in the same order, two edges after the change.
- R5: A set flag stays set until a cycle with `rd_en` high. The clock edge that ends that cycle clears every flag that has no new change in that cycle.
- R6: A change that would set a flag at the same edge as a read leaves that flag set.
- R7: `irq_o` is high exactly when some flag is set whose bit in the mask register (address 2, bits 3:0, same order as R4) is one.
- R8: In modem mode, once clear-to-send has been synchronized high and sampled while `tx_busy` is low, `tx_valid` and `up_ready` are held low. Once it is sampled low again, they follow `up_valid` and `tx_ready`, and `tx_data` carries `up_data`.
- R9: While `tx_busy` is high, the gate state of R8 does not change, whatever clear-to-send does.
- R10: In modem mode, `rts_o` is low one cycle after `up_valid` or `tx_busy` is high, and high one cycle after both are low.
- R11: After reset, `dtr_o`, `rts_o` are high, `irq_o` is low, the flags are zero and the mode is not modem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 command, 2 mask |
| wr_data | input | 4 | Write data |
| rd_en | input | 1 | Status read strobe, clears flags |
| rd_data | output | 8 | Status: levels in 7:4, change flags in 3:0 |
| irq_o | output | 1 | Interrupt request |
| ri_i | input | 1 | Ring indicate, active low, asynchronous |
| dsr_i | input | 1 | Data-set ready, active low, asynchronous |
| dcd_i | input | 1 | Carrier detect, active low, asynchronous |
| cts_i | input | 1 | Clear-to-send, active low, asynchronous |
| dtr_o | output | 1 | Terminal ready, active low |
| rts_o | output | 1 | Request to send, active low |
| up_valid | input | 1 | Upstream character valid |
| up_ready | output | 1 | Upstream character accepted |
| up_data | input | DATA_W | Upstream character |
| tx_valid | output | 1 | Character offered to transmitter core |
| tx_ready | input | 1 | Transmitter core can take a character |
| tx_data | output | DATA_W | Character to transmitter core |
| tx_busy | input | 1 | Transmitter core is shifting a frame |

## Verification
The hardest case to reach from the ports is a new line change that lands on the same edge as a status read. The synchronizer pipeline hides when a flag will be set, so the bench counts edges exactly. It changes the data-set-ready line at a falling edge, lets two rising edges pass, then raises `rd_en` for the third edge, with an older ring flag already pending. The read must clear the old flag and keep the new one. Clear-to-send rising during a busy frame is reached by holding `tx_busy` high across the whole synchronizer delay and then checking that the gate closes only after `tx_busy` falls.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int NUM_LINES = 4;
  localparam int WDATA_W   = 4;
  localparam int STATUS_W  = 2 * NUM_LINES;
  localparam logic [WDATA_W-1:0] MODE_MODEM = 4'h3;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_CMD  = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  localparam int CMD_DTR_ON  = 0;
  localparam int CMD_DTR_OFF = 1;
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] change_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign level_o  = stage_q[STAGES-1];
  assign change_o = stage_q[STAGES-1] ^ prev_q;

  // R4: a change pulse always reflects a real step of the synchronized level
  assert_change_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (change_o != '0) |=> (prev_q == $past(level_o)));
endmodule

// File: rtl/modem_change_flags.sv
module modem_change_flags #(
  parameter int NUM = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable_i,
  input  logic [NUM-1:0] set_i,
  input  logic           clr_i,
  input  logic [NUM-1:0] mask_i,
  output logic [NUM-1:0] flags_o,
  output logic           irq_o
);
  logic [NUM-1:0] flags_q;
  logic [NUM-1:0] set_gated;

  assign set_gated = enable_i ? set_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~{NUM{clr_i}}) | set_gated;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & mask_i);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_read_race_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_gated != '0) |=> ((flags_q & $past(set_gated)) == $past(set_gated)));

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  assert_no_set_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> ((flags_q & ~$past(flags_q)) == '0));
endmodule

// File: rtl/modem_flow_gate.sv
module modem_flow_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modem_i,
  input  logic              cts_level_i,
  input  logic              tx_busy,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              rts_o
);
  logic hold_q;
  logic rts_q;
  logic gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (!tx_busy) hold_q <= modem_i & cts_level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b1;
    else        rts_q <= ~(up_valid | tx_busy);
  end

  assign gate     = hold_q & modem_i;
  assign tx_valid = up_valid & ~gate;
  assign up_ready = tx_ready & ~gate;
  assign tx_data  = up_data;
  assign rts_o    = modem_i ? rts_q : 1'b1;

  assert_frame_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(hold_q));

  assert_cts_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_i && cts_level_i && !tx_busy) |=> (!tx_valid && !up_ready) || !modem_i);

  assert_rts_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_i && up_valid) |=> (!rts_o || !modem_i));
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
  import modem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [WDATA_W-1:0]  wr_data,
  input  logic                rd_en,
  output logic [STATUS_W-1:0] rd_data,
  output logic                irq_o,
  input  logic                ri_i,
  input  logic                dsr_i,
  input  logic                dcd_i,
  input  logic                cts_i,
  output logic                dtr_o,
  output logic                rts_o,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic [DATA_W-1:0]   up_data,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [DATA_W-1:0]   tx_data,
  input  logic                tx_busy
);
  logic [WDATA_W-1:0]   mode_q;
  logic [NUM_LINES-1:0] mask_q;
  logic                 dtr_q;
  logic                 modem;
  logic [NUM_LINES-1:0] lines_raw;
  logic [NUM_LINES-1:0] lines_lvl;
  logic [NUM_LINES-1:0] lines_chg;
  logic [NUM_LINES-1:0] flags;
  logic                 wr_mode, wr_cmd, wr_mask;
  logic                 unused_cmd_bits;

  assign lines_raw = {cts_i, dcd_i, dsr_i, ri_i};
  assign modem     = (mode_q == MODE_MODEM);
  assign wr_mode   = wr_en && (wr_addr == ADDR_MODE);
  assign wr_cmd    = wr_en && (wr_addr == ADDR_CMD);
  assign wr_mask   = wr_en && (wr_addr == ADDR_MASK);
  assign unused_cmd_bits = ^wr_data[WDATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
      dtr_q  <= 1'b1;
    end else begin
      if (wr_mode) mode_q <= wr_data;
      if (wr_mask) mask_q <= wr_data[NUM_LINES-1:0];
      if (wr_cmd) begin
        if (wr_data[CMD_DTR_OFF])     dtr_q <= 1'b1;
        else if (wr_data[CMD_DTR_ON]) dtr_q <= 1'b0;
      end
    end
  end

  assign dtr_o = modem ? dtr_q : 1'b1;

  modem_line_sync #(.WIDTH(NUM_LINES), .STAGES(2)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_i    (lines_raw),
    .level_o  (lines_lvl),
    .change_o (lines_chg)
  );

  modem_change_flags #(.NUM(NUM_LINES)) i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (modem),
    .set_i    (lines_chg),
    .clr_i    (rd_en),
    .mask_i   (mask_q),
    .flags_o  (flags),
    .irq_o    (irq_o)
  );

  modem_flow_gate #(.DATA_W(DATA_W)) i_flow (
    .clk         (clk),
    .rst_n       (rst_n),
    .modem_i     (modem),
    .cts_level_i (lines_lvl[NUM_LINES-1]),
    .tx_busy     (tx_busy),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_data     (up_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .rts_o       (rts_o)
  );

  assign rd_data = {lines_lvl, flags};

  assert_dtr_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (modem && wr_cmd && wr_data[CMD_DTR_ON] && !wr_data[CMD_DTR_OFF]) |=> !dtr_o);

  assert_dtr_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (modem && wr_cmd && wr_data[CMD_DTR_OFF]) |=> dtr_o);

  assert_idle_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !modem |-> (dtr_o && rts_o));

  assert_mode_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wr_data != MODE_MODEM) |=> (dtr_o && rts_o));
endmodule

// File: tb/test_uart_modem_ctrl.sv
module test_uart_modem_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_o;
  logic       ri_i = 1'b1, dsr_i = 1'b1, dcd_i = 1'b1, cts_i = 1'b1;
  logic       dtr_o, rts_o;
  logic       up_valid = 1'b0, tx_ready = 1'b0, tx_busy = 1'b0;
  logic       up_ready, tx_valid;
  logic [7:0] up_data = 8'h00, tx_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [3:0] MASK = 4'b0100;
  // {inputs cts,dcd,dsr,ri ; expected status byte}
  localparam logic [11:0] VEC [6] = '{
    {4'b1110, 8'hE1},
    {4'b1100, 8'hC2},
    {4'b0011, 8'h3F},
    {4'b0011, 8'h30},
    {4'b1111, 8'hFC},
    {4'b1011, 8'hB4}
  };

  always #4 clk = ~clk;

  uart_modem_ctrl i_uart_modem_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o),
    .ri_i(ri_i), .dsr_i(dsr_i), .dcd_i(dcd_i), .cts_i(cts_i),
    .dtr_o(dtr_o), .rts_o(rts_o),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_busy(tx_busy)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lines(input logic [3:0] v);
    {cts_i, dcd_i, dsr_i, ri_i} = v;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_status();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 dtr", {7'd0, dtr_o}, 8'd1);
    chk("R11 rts", {7'd0, rts_o}, 8'd1);
    chk("R11 irq", {7'd0, irq_o}, 8'd0);
    chk("R11 status", rd_data, 8'hF0);

    // R1 / R3: not modem mode
    wr(2'd0, 4'hB);
    wr(2'd1, 4'b0001);
    chk("R1 dtr in mode B", {7'd0, dtr_o}, 8'd1);
    wr(2'd0, 4'h2);
    wr(2'd1, 4'b0001);
    chk("R3 dtr idle", {7'd0, dtr_o}, 8'd1);
    lines(4'b1110);
    wait_cycles(4);
    chk("R3 no flag", {4'd0, rd_data[3:0]}, 8'd0);
    up_valid = 1'b1; tx_ready = 1'b1; up_data = 8'hC3;
    lines(4'b0110);
    wait_cycles(4);
    lines(4'b1110);
    wait_cycles(4);
    chk("R3 cts no gate", {7'd0, tx_valid}, 8'd1);
    chk("R3 rts idle", {7'd0, rts_o}, 8'd1);
    up_valid = 1'b0;
    lines(4'b1111);
    wait_cycles(4);
    chk("R3 still no flag", {4'd0, rd_data[3:0]}, 8'd0);

    // R1 / R2: enter modem mode, DTR commands
    wr(2'd0, 4'h3);
    chk("R1 dtr follows stored enable", {7'd0, dtr_o}, 8'd0);
    wr(2'd1, 4'b0010);
    chk("R2 dtr off", {7'd0, dtr_o}, 8'd1);
    wr(2'd1, 4'b0001);
    chk("R2 dtr on", {7'd0, dtr_o}, 8'd0);
    wr(2'd1, 4'b0011);
    chk("R2 both -> off", {7'd0, dtr_o}, 8'd1);
    chk("R4 no spurious flag", {4'd0, rd_data[3:0]}, 8'd0);

    // R4 R5 R7: vector table
    wr(2'd2, MASK);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lines(VEC[i][11:8]);
      wait_cycles(4);
      chk("R4 status", rd_data, VEC[i][7:0]);
      chk("R7 irq", {7'd0, irq_o}, {7'd0, |(VEC[i][3:0] & MASK)});
      wait_cycles(2);
      chk("R5 sticky", {4'd0, rd_data[3:0]}, {4'd0, VEC[i][3:0]});
      read_status();
      chk("R5 cleared", {4'd0, rd_data[3:0]}, 8'd0);
    end

    // R6: change lands on the read edge
    lines(4'b1010);
    wait_cycles(4);
    chk("R6 pre ring flag", {4'd0, rd_data[3:0]}, 8'h01);
    lines(4'b1000);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rd_en = 1'b1;
    chk("R6 before edge", {4'd0, rd_data[3:0]}, 8'h01);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 race kept", {4'd0, rd_data[3:0]}, 8'h02);
    read_status();

    // R8 R10: flow control
    up_valid = 1'b1; tx_ready = 1'b1; up_data = 8'h5A; tx_busy = 1'b0;
    wait_cycles(2);
    chk("R8 gated valid", {7'd0, tx_valid}, 8'd0);
    chk("R8 gated ready", {7'd0, up_ready}, 8'd0);
    chk("R10 rts active", {7'd0, rts_o}, 8'd0);
    lines(4'b0000);
    wait_cycles(4);
    chk("R8 open valid", {7'd0, tx_valid}, 8'd1);
    chk("R8 open ready", {7'd0, up_ready}, 8'd1);
    chk("R8 data", tx_data, 8'h5A);

    // R9: cts rises while busy
    tx_busy = 1'b1;
    lines(4'b1000);
    wait_cycles(6);
    chk("R9 frame finishes", {7'd0, tx_valid}, 8'd1);
    tx_busy = 1'b0;
    wait_cycles(1);
    chk("R9 gate after frame", {7'd0, tx_valid}, 8'd0);
    up_valid = 1'b0;
    wait_cycles(2);
    chk("R10 rts released", {7'd0, rts_o}, 8'd1);

    // R3: leave modem mode
    up_valid = 1'b1;
    wr(2'd0, 4'h0);
    chk("R3 no gate outside", {7'd0, tx_valid}, 8'd1);
    chk("R3 dtr high", {7'd0, dtr_o}, 8'd1);
    chk("R3 rts high", {7'd0, rts_o}, 8'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule